// File: doc/BRIEF.md
# Endpoint Control and Status Register

This block is the per-endpoint control and status word of a device-side serial bus controller. Firmware writes it to enable the endpoint, pick its transfer type and direction, request a STALL answer and mark a transmit bank as loaded. The protocol engine raises event flags in the same word: SETUP received, data received in bank 0 or bank 1, STALL handshake sent, and transmit finished. A level interrupt is raised while any flag is pending and the mask input allows it.

The flags are write-0-to-clear: a 1 written to a flag bit leaves it alone, so a read-modify-write that only means to change a control field must write 1 to every flag bit. A firmware write does not land at once. It travels through a short synchronizer and only shows on readback and on the control outputs some cycles later, so firmware polls until the value reads back. When the protocol engine raises a flag on the same edge that a firmware clear lands, the flag stays set.

Top module: `ep_csr_reg`

## Requirements
- R1: After reset the readback word is 0 (type control, direction OUT, endpoint disabled, no flag set), every control output is 0 and `ep_irq` is low.
- R2: Word layout: bit 0 transmit-done, bit 1 receive bank 0, bit 2 setup received, bit 3 stall sent, bit 4 transmit-ready, bit 5 force-stall, bit 6 receive bank 1, bit 7 direction IN, bits 10:8 endpoint type, bit 15 enable; bits 11 to 14 always read 0.
- R3: A write sampled at clock edge k becomes visible on readback and on the control outputs at edge k+SYNC_STAGES (default 2) and not before.
- R4: Control fields (enable, type, direction, force-stall, transmit-ready) take the written value, and the control outputs follow the stored value.
- R5: All eight values of the 3-bit type field are stored and read back unchanged (0 control, 1 isochronous OUT, 2 bulk OUT, 3 interrupt OUT, 5 isochronous IN, 6 bulk IN, 7 interrupt IN, 4 unused).
- R6: An event input high at an edge sets its flag at that edge, and the flag then stays set until firmware clears it.
- R7: A write landing with 0 in a flag bit clears that flag; a 1 leaves it unchanged; other flags are not touched.
- R8: An event raised on the same edge that a clear of its flag lands leaves the flag set.
- R9: `ep_irq` is high exactly while `irq_mask_en` is high and at least one flag is set.
- R10: Writing 1 to a flag bit that is clear does not set it.
- R11: Writes on consecutive cycles each land, in order, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fw_wr_en | input | 1 | Firmware write strobe |
| fw_wr_data | input | 16 | Firmware write word |
| fw_rd_data | output | 16 | Readback word |
| irq_mask_en | input | 1 | Interrupt enable for this endpoint |
| evt_setup | input | 1 | Protocol engine: SETUP received |
| evt_rx_bank0 | input | 1 | Protocol engine: data in bank 0 |
| evt_rx_bank1 | input | 1 | Protocol engine: data in bank 1 |
| evt_stall_sent | input | 1 | Protocol engine: STALL handshake sent |
| evt_tx_done | input | 1 | Protocol engine: transmit finished |
| ctl_enable | output | 1 | Endpoint enabled |
| ctl_dir_in | output | 1 | Data stage direction is IN |
| ctl_type | output | 3 | Endpoint transfer type |
| ctl_force_stall | output | 1 | Answer with STALL |
| ctl_tx_ready | output | 1 | Transmit bank loaded |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
Event flags appear one edge after the event input is sampled, firmware writes appear SYNC_STAGES edges after the strobe is sampled, and the interrupt follows the flags in the same cycle. The bench drives on the falling edge and samples on the next falling edges, counting edges from the capturing one, so a write is checked as still old one edge before it is due and new at the due edge. The coincident set-and-clear case is built by raising the event exactly in the cycle whose rising edge lands the clear.

// File: rtl/epcsr_pkg.sv
package epcsr_pkg;

  localparam int CSR_W     = 16;
  localparam int NUM_FLAGS = 5;

  // flag index -> bit position in the word
  // index 0 tx_done, 1 rx bank0, 2 setup, 3 stall sent, 4 rx bank1
  localparam int FLAG_POS [NUM_FLAGS] = '{0, 1, 2, 3, 6};

  localparam int POS_TX_READY    = 4;
  localparam int POS_FORCE_STALL = 5;
  localparam int POS_DIR_IN      = 7;
  localparam int POS_TYPE_LO     = 8;
  localparam int TYPE_W          = 3;
  localparam int POS_ENABLE      = 15;

  typedef enum logic [TYPE_W-1:0] {
    EPT_CONTROL  = 3'd0,
    EPT_ISO_OUT  = 3'd1,
    EPT_BULK_OUT = 3'd2,
    EPT_INT_OUT  = 3'd3,
    EPT_UNUSED   = 3'd4,
    EPT_ISO_IN   = 3'd5,
    EPT_BULK_IN  = 3'd6,
    EPT_INT_IN   = 3'd7
  } ep_type_e;

  typedef struct packed {
    logic     enable;
    ep_type_e ep_type;
    logic     dir_in;
    logic     force_stall;
    logic     tx_ready;
  } ctl_t;

  // event wins over a landing clear; writing 1 keeps the flag
  function automatic logic flag_next(logic cur, logic hw_set, logic apply, logic wbit);
    return hw_set | (cur & ~(apply & ~wbit));
  endfunction

  function automatic ctl_t ctl_from_word(logic [CSR_W-1:0] w);
    ctl_t c;
    c.enable      = w[POS_ENABLE];
    c.ep_type     = ep_type_e'(w[POS_TYPE_LO +: TYPE_W]);
    c.dir_in      = w[POS_DIR_IN];
    c.force_stall = w[POS_FORCE_STALL];
    c.tx_ready    = w[POS_TX_READY];
    return c;
  endfunction

  function automatic logic [CSR_W-1:0] pack_word(ctl_t c, logic [NUM_FLAGS-1:0] f);
    logic [CSR_W-1:0] w;
    w = '0;
    w[POS_ENABLE]               = c.enable;
    w[POS_TYPE_LO +: TYPE_W]    = c.ep_type;
    w[POS_DIR_IN]               = c.dir_in;
    w[POS_FORCE_STALL]          = c.force_stall;
    w[POS_TX_READY]             = c.tx_ready;
    for (int i = 0; i < NUM_FLAGS; i++) w[FLAG_POS[i]] = f[i];
    return w;
  endfunction

endpackage

// File: rtl/ep_csr_sync_pipe.sv
module ep_csr_sync_pipe #(
  parameter int STAGES = 2,
  parameter int W      = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic [STAGES-1:0] vld;
  logic [W-1:0]      dat [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[s] <= 1'b0;
          dat[s] <= '0;
        end else begin
          vld[s] <= in_valid;
          dat[s] <= in_data;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld[s] <= 1'b0;
          dat[s] <= '0;
        end else begin
          vld[s] <= vld[s-1];
          dat[s] <= dat[s-1];
        end
      end
    end
  end

  assign out_valid = vld[STAGES-1];
  assign out_data  = dat[STAGES-1];

endmodule

// File: rtl/ep_csr_flag.sv
module ep_csr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic apply,
  input  logic wbit,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= epcsr_pkg::flag_next(q, hw_set, apply, wbit);
  end

endmodule

// File: rtl/ep_csr_reg.sv
module ep_csr_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fw_wr_en,
  input  logic [15:0] fw_wr_data,
  output logic [15:0] fw_rd_data,
  input  logic        irq_mask_en,
  input  logic        evt_setup,
  input  logic        evt_rx_bank0,
  input  logic        evt_rx_bank1,
  input  logic        evt_stall_sent,
  input  logic        evt_tx_done,
  output logic        ctl_enable,
  output logic        ctl_dir_in,
  output logic [2:0]  ctl_type,
  output logic        ctl_force_stall,
  output logic        ctl_tx_ready,
  output logic        ep_irq
);
  import epcsr_pkg::*;

  // write as it lands after the synchronizer
  logic             apply_strobe;
  logic [CSR_W-1:0] apply_word;
  logic [NUM_FLAGS-1:0] evt_vec;
  logic [NUM_FLAGS-1:0] flags;
  ctl_t             ctl_q;

  ep_csr_sync_pipe #(.STAGES(SYNC_STAGES), .W(CSR_W)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (fw_wr_en),
    .in_data  (fw_wr_data),
    .out_valid(apply_strobe),
    .out_data (apply_word)
  );

  assign evt_vec = {evt_rx_bank1, evt_stall_sent, evt_setup, evt_rx_bank0, evt_tx_done};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    ep_csr_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .hw_set(evt_vec[i]),
      .apply (apply_strobe),
      .wbit  (apply_word[FLAG_POS[i]]),
      .q     (flags[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ctl_q <= '0;
    else if (apply_strobe) ctl_q <= ctl_from_word(apply_word);
  end

  assign fw_rd_data      = pack_word(ctl_q, flags);
  assign ctl_enable      = ctl_q.enable;
  assign ctl_dir_in      = ctl_q.dir_in;
  assign ctl_type        = ctl_q.ep_type;
  assign ctl_force_stall = ctl_q.force_stall;
  assign ctl_tx_ready    = ctl_q.tx_ready;
  assign ep_irq          = irq_mask_en & (|flags);

endmodule

// File: rtl/ep_csr_checks.sv
module ep_csr_checks #(
  parameter int SYNC_STAGES = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fw_wr_en,
  input logic [15:0] fw_rd_data,
  input logic        irq_mask_en,
  input logic        evt_rx_bank0,
  input logic        ep_irq,
  input logic        apply_strobe,
  input logic [15:0] apply_word
);

  localparam logic [15:0] CTL_BITS = 16'h87B0;

  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rx_bank0 |=> fw_rd_data[1]);

  a_r7_clear_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fw_rd_data[1]) |-> ($past(apply_strobe) && !$past(apply_word[1])));

  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rx_bank0 && apply_strobe && !apply_word[1]) |=> fw_rd_data[1]);

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fw_wr_en |-> ##SYNC_STAGES apply_strobe);

  a_r4_ctl_only_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_strobe |=> $stable(fw_rd_data & CTL_BITS));

  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> irq_mask_en);

  a_r2_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fw_rd_data[14:11] == 4'd0);

endmodule

bind ep_csr_reg ep_csr_checks #(.SYNC_STAGES(SYNC_STAGES)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .fw_wr_en    (fw_wr_en),
  .fw_rd_data  (fw_rd_data),
  .irq_mask_en (irq_mask_en),
  .evt_rx_bank0(evt_rx_bank0),
  .ep_irq      (ep_irq),
  .apply_strobe(apply_strobe),
  .apply_word  (apply_word)
);

// File: tb/test_ep_csr_reg.sv
module test_ep_csr_reg;
  localparam int SYNC = 2;
  localparam logic [15:0] CTL_BITS  = 16'h87B0;
  localparam logic [15:0] FLAG_BITS = 16'h004F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fw_wr_en = 1'b0;
  logic [15:0] fw_wr_data = '0;
  logic [15:0] fw_rd_data;
  logic        irq_mask_en = 1'b1;
  logic [4:0]  evt = '0;
  logic        ctl_enable, ctl_dir_in, ctl_force_stall, ctl_tx_ready, ep_irq;
  logic [2:0]  ctl_type;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] model = '0;

  always #4 clk = ~clk;

  ep_csr_reg #(.SYNC_STAGES(SYNC)) i_ep_csr_reg (
    .clk(clk), .rst_n(rst_n), .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data),
    .fw_rd_data(fw_rd_data), .irq_mask_en(irq_mask_en),
    .evt_setup(evt[2]), .evt_rx_bank0(evt[1]), .evt_rx_bank1(evt[4]),
    .evt_stall_sent(evt[3]), .evt_tx_done(evt[0]),
    .ctl_enable(ctl_enable), .ctl_dir_in(ctl_dir_in), .ctl_type(ctl_type),
    .ctl_force_stall(ctl_force_stall), .ctl_tx_ready(ctl_tx_ready), .ep_irq(ep_irq));

  // bit position of flag index i in the word (R2)
  function automatic logic [15:0] fbit(int i);
    case (i)
      0: return 16'h0001;
      1: return 16'h0002;
      2: return 16'h0004;
      3: return 16'h0008;
      default: return 16'h0040;
    endcase
  endfunction

  // model update of a landed write (R4, R7, R10)
  function automatic logic [15:0] landed(logic [15:0] cur, logic [15:0] w);
    return (w & CTL_BITS) | (cur & w & FLAG_BITS);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic check_outputs(string req);
    check(req, {25'd0, ctl_enable, ctl_type, ctl_dir_in, ctl_force_stall, ctl_tx_ready},
          {25'd0, model[15], model[10:8], model[7], model[5], model[4]});
  endtask

  task automatic fw_write(logic [15:0] w);
    fw_wr_en = 1'b1; fw_wr_data = w;
    @(negedge clk);
    fw_wr_en = 1'b0;
    repeat (SYNC) @(negedge clk);
    model = landed(model, w);
  endtask

  task automatic pulse(int i);
    evt = fbit(i) == 16'h0040 ? 5'b10000 : fbit(i)[4:0];
    @(negedge clk);
    evt = '0;
    model = model | fbit(i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", fw_rd_data, 16'h0000);
    check("R1", ep_irq, 0);
    check_outputs("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 latency: old value until the SYNC-th edge after capture
    fw_wr_en = 1'b1; fw_wr_data = 16'h8000 | FLAG_BITS;
    @(negedge clk); fw_wr_en = 1'b0;
    check("R3 early", fw_rd_data, 16'h0000);
    repeat (SYNC - 1) @(negedge clk);
    check("R3 early", fw_rd_data, 16'h0000);
    check("R3 early", ctl_enable, 0);
    @(negedge clk);
    model = 16'h8000;
    check("R3 due", fw_rd_data, 16'h8000);
    check("R3 due", ctl_enable, 1);

    // R4 R5 R2 sweep of every control combination
    for (int v = 0; v < 128; v++) begin
      logic [15:0] w;
      w = FLAG_BITS;
      w[15] = v[6]; w[10:8] = v[5:3]; w[7] = v[2]; w[5] = v[1]; w[4] = v[0];
      w[14:11] = v[3:0];  // spare bits written, must read 0 (R2)
      fw_write(w);
      check("R4 R5 R2 readback", fw_rd_data, model);
      check_outputs("R4 outputs");
    end

    // R10 writing 1 to clear flags does not set them
    fw_write(16'hFFFF);
    check("R10", fw_rd_data & FLAG_BITS, 16'h0000);
    check("R9 no flags", ep_irq, 0);

    // per flag: R6, R7, R9, R8
    for (int i = 0; i < 5; i++) begin
      pulse(i);
      check("R6 set", fw_rd_data, model);
      check("R9 irq", ep_irq, 1);
      repeat (3) @(negedge clk);
      check("R6 hold", fw_rd_data, model);
      irq_mask_en = 1'b0; #1;
      check("R9 masked", ep_irq, 0);
      irq_mask_en = 1'b1;
      // set another flag so a clear of i must not touch it
      pulse((i + 1) % 5);
      fw_write(model | FLAG_BITS);
      check("R7 write one keeps", fw_rd_data, model);
      fw_write((model & CTL_BITS) | (FLAG_BITS & ~fbit(i)));
      check("R7 write zero clears", fw_rd_data, model);
      fw_write(model & CTL_BITS);
      check("R7 clear all", fw_rd_data & FLAG_BITS, 16'h0000);
      check("R9 irq drops", ep_irq, 0);
      // R8: clear of flag i lands on the same edge as its event, flag set before
      pulse(i);
      fw_wr_en = 1'b1; fw_wr_data = model & CTL_BITS;
      @(negedge clk); fw_wr_en = 1'b0;
      repeat (SYNC - 1) @(negedge clk);
      evt = fbit(i) == 16'h0040 ? 5'b10000 : fbit(i)[4:0];
      @(negedge clk); evt = '0;
      model = (model & CTL_BITS) | fbit(i);
      check("R8 event wins", fw_rd_data, model);
      fw_write(model & CTL_BITS);
      check("R8 then clears", fw_rd_data & FLAG_BITS, 16'h0000);
    end

    // R11 back-to-back writes land one cycle apart, in order
    fw_wr_en = 1'b1; fw_wr_data = 16'h8210 | FLAG_BITS;
    @(negedge clk);
    fw_wr_data = 16'h0680 | FLAG_BITS;
    @(negedge clk);
    fw_wr_en = 1'b0;
    repeat (SYNC - 1) @(negedge clk);
    check("R11 first", fw_rd_data, 16'h8210);
    @(negedge clk);
    check("R11 second", fw_rd_data, 16'h0680);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule